// File: doc/BRIEF.md
# SMI Trigger with Feature Negotiation

This block turns writes to a power-management command port into system management interrupt (SMI) requests for a set of CPUs. Two reserved command values are not SMIs at all; they produce a single-cycle ACPI-on or ACPI-off pulse for the neighbouring ACPI register file. Every other command value raises an SMI, provided the APM-command enable bit is set. The SMI goes either to the CPU that performed the write or to every CPU at once.

The choice between these two delivery modes comes from a one-shot feature negotiation. Firmware first reads a fixed supported-feature mask. It then writes a requested mask one byte at a time and writes a commit strobe. A commit that asks only for supported bits copies the request into the negotiated mask and sets an ok flag. From then on the negotiated features are frozen until reset.

The block also holds three small registers:
- an SMI enable register, whose global-enable bit can be frozen by a sticky lock bit in a power-management configuration register;
- the lock-bearing power-management configuration register itself;
- a reset-control register that can request a system reset.

All access goes through one byte-wide write/read port with registered read data.

Top module: `smi_hub`

## Requirements
- R1: After reset, every output pulse is low and the following registers read zero: requested mask, negotiated mask, ok flag, SMI enable, PM configuration and reset control. The supported mask (addresses 0x00..0x07) reads the configured host feature value. Read data is registered: it shows the addressed byte one cycle after the address is presented. Unmapped addresses read 0.
- R2: A write to the command port (0x11) of value 0xF1 gives a one-cycle acpi_on pulse, and a write of 0xF0 gives a one-cycle acpi_off pulse. Both appear in the cycle after the write, and neither raises an SMI, whatever the enable bits are.
- R3: A write of any other value to 0x11 raises an SMI in the cycle after the write only when bit 5 (APM-command enable) of the SMI enable register (0x12) is set.
- R4: If bit 0 (broadcast) of the negotiated mask is set, an SMI asserts every bit of smi_req. Otherwise it asserts only the bit selected by cpu_idx.
- R5: A commit (any write to 0x10) whose requested mask has a bit outside the supported mask leaves the ok flag (bit 0 of 0x10) at 0 and leaves the negotiated mask unchanged.
- R6: A commit with a valid requested mask copies it into the negotiated mask (0x18..0x1F) and sets the ok flag.
- R7: Once the ok flag is set, later commits change neither the ok flag nor the negotiated mask.
- R8: The requested mask (0x08..0x0F) and the negotiated mask are accessed little-endian. Byte lane k holds mask bits 8k+7..8k.
- R9: Bit 4 of the PM configuration register (0x13) is the lock bit. Once it is set it cannot be cleared, and bit 0 of 0x12 ignores writes until reset. The other bits of 0x12 stay writable.
- R10: A write to reset control (0x14) with bit 2 set gives a one-cycle sys_rst_req pulse and stores nothing. Any other write stores only bits 3 and 1. Reads return the stored value.
- R11: Each SMI request lasts one cycle unless a further command write follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| cpu_idx | input | CPU_W | Index of the CPU performing the current write |
| smi_req | output | NCPU | Per-CPU SMI request pulses |
| acpi_on | output | 1 | ACPI enable pulse |
| acpi_off | output | 1 | ACPI disable pulse |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The command decode is swept over all 256 command values, with cpu_idx rotating through every CPU. This separates the two ACPI codes from genuine SMI commands and confirms the one-hot target before negotiation and the all-CPU target after it. Commits are tried with requests that have illegal bits in the low and in the high byte lane, then with a legal request, then with a changed request after success. These cases distinguish a rejected commit, an accepted commit and a locked one. The lock and reset-control writes use patterns that mix the frozen or discarded bits with live ones, so a wrongly masked bit shows up in the read-back.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int FEAT_W     = 64;
  localparam int FEAT_BYTES = FEAT_W / 8;
  localparam int ADDR_W     = 5;

  localparam logic [ADDR_W-1:0] A_COMMIT = 5'h10;
  localparam logic [ADDR_W-1:0] A_CMD    = 5'h11;
  localparam logic [ADDR_W-1:0] A_SMIEN  = 5'h12;
  localparam logic [ADDR_W-1:0] A_PMCFG  = 5'h13;
  localparam logic [ADDR_W-1:0] A_RSTCTL = 5'h14;

  localparam logic [1:0] BANK_SUP = 2'd0;
  localparam logic [1:0] BANK_REQ = 2'd1;
  localparam logic [1:0] BANK_CTL = 2'd2;
  localparam logic [1:0] BANK_NEG = 2'd3;

  localparam int APM_EN_BIT  = 5;
  localparam int GBL_EN_BIT  = 0;
  localparam int LOCK_BIT    = 4;
  localparam int RST_REQ_BIT = 2;
  localparam logic [7:0] RST_KEEP = 8'h0A;
endpackage

// File: rtl/smi_feature_neg.sv
module smi_feature_neg
  import smi_pkg::*;
#(
  parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'h1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_we,
  input  logic [2:0]        req_lane,
  input  logic [7:0]        wdata,
  input  logic              commit,
  output logic [FEAT_W-1:0] requested,
  output logic [FEAT_W-1:0] negotiated,
  output logic              ok
);
  localparam logic [FEAT_W-1:0] ILLEGAL = ~HOST_FEATURES;

  for (genvar b = 0; b < FEAT_BYTES; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) requested[b*8 +: 8] <= '0;
      else if (req_we && req_lane == 3'(b)) requested[b*8 +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      negotiated <= '0;
      ok         <= 1'b0;
    end else if (commit && !ok && ((requested & ILLEGAL) == '0)) begin
      negotiated <= requested;
      ok         <= 1'b1;
    end
  end

  // R7
  ok_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ok |=> ok);
  // R7
  neg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ok |=> $stable(negotiated));
  // R5
  neg_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (negotiated & ILLEGAL) == '0);
endmodule

// File: rtl/smi_cmd_fanout.sv
module smi_cmd_fanout #(
  parameter int         NCPU     = 4,
  parameter int         CPU_W    = (NCPU > 1) ? $clog2(NCPU) : 1,
  parameter logic [7:0] ON_CMD   = 8'hF1,
  parameter logic [7:0] OFF_CMD  = 8'hF0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [7:0]       cmd,
  input  logic             apm_en,
  input  logic             bcast,
  input  logic [CPU_W-1:0] cpu_idx,
  output logic [NCPU-1:0]  smi_req,
  output logic             acpi_on,
  output logic             acpi_off
);
  logic is_on, is_off, fire;

  assign is_on  = cmd_we && (cmd == ON_CMD);
  assign is_off = cmd_we && (cmd == OFF_CMD);
  assign fire   = cmd_we && !is_on && !is_off && apm_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      acpi_on  <= 1'b0;
      acpi_off <= 1'b0;
    end else begin
      acpi_on  <= is_on;
      acpi_off <= is_off;
    end
  end

  for (genvar i = 0; i < NCPU; i++) begin : g_cpu
    always_ff @(posedge clk) begin
      if (rst) smi_req[i] <= 1'b0;
      else     smi_req[i] <= fire && (bcast || cpu_idx == CPU_W'(i));
    end
  end

  // R3
  smi_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|smi_req) |-> $past(cmd_we) && $past(apm_en));
  // R4
  smi_single_chk: assert property (@(posedge clk) disable iff (rst)
    ((|smi_req) && !$past(bcast)) |-> ($countones(smi_req) == 1));
  // R4
  smi_all_chk: assert property (@(posedge clk) disable iff (rst)
    ((|smi_req) && $past(bcast)) |-> (&smi_req));
  // R2
  acpi_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (acpi_on || acpi_off) |-> (smi_req == '0));
endmodule

// File: rtl/smi_pm_regs.sv
module smi_pm_regs
  import smi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_we,
  input  logic       cfg_we,
  input  logic       rctl_we,
  input  logic [7:0] wdata,
  output logic [7:0] smi_en,
  output logic [7:0] pm_cfg,
  output logic [7:0] rst_cnt,
  output logic       sys_rst_req
);
  logic locked;
  assign locked = pm_cfg[LOCK_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_en <= '0;
    end else if (en_we) begin
      smi_en <= wdata;
      if (locked) smi_en[GBL_EN_BIT] <= smi_en[GBL_EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_cfg <= '0;
    end else if (cfg_we) begin
      pm_cfg <= wdata;
      pm_cfg[LOCK_BIT] <= pm_cfg[LOCK_BIT] | wdata[LOCK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_cnt     <= '0;
      sys_rst_req <= 1'b0;
    end else begin
      sys_rst_req <= rctl_we && wdata[RST_REQ_BIT];
      if (rctl_we && !wdata[RST_REQ_BIT]) rst_cnt <= wdata & RST_KEEP;
    end
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
  // R9
  gbl_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> $stable(smi_en[GBL_EN_BIT]));
  // R10
  rst_nostore_chk: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |-> $stable(rst_cnt));
endmodule

// File: rtl/smi_hub.sv
module smi_hub
  import smi_pkg::*;
#(
  parameter int                NCPU          = 4,
  parameter int                CPU_W         = (NCPU > 1) ? $clog2(NCPU) : 1,
  parameter logic [FEAT_W-1:0] HOST_FEATURES = 64'h1,
  parameter int                BCAST_BIT     = 0,
  parameter logic [7:0]        ON_CMD        = 8'hF1,
  parameter logic [7:0]        OFF_CMD       = 8'hF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [CPU_W-1:0]  cpu_idx,
  output logic [NCPU-1:0]   smi_req,
  output logic              acpi_on,
  output logic              acpi_off,
  output logic              sys_rst_req
);
  logic [1:0] bank;
  logic [2:0] lane;
  assign bank = reg_addr[4:3];
  assign lane = reg_addr[2:0];

  logic [FEAT_W-1:0] requested, negotiated;
  logic              ok;
  logic [7:0]        smi_en, pm_cfg, rst_cnt;

  smi_feature_neg #(.HOST_FEATURES(HOST_FEATURES)) u_neg (
    .clk       (clk),
    .rst       (rst),
    .req_we    (reg_we && bank == BANK_REQ),
    .req_lane  (lane),
    .wdata     (reg_wdata),
    .commit    (reg_we && reg_addr == A_COMMIT),
    .requested (requested),
    .negotiated(negotiated),
    .ok        (ok)
  );

  smi_cmd_fanout #(
    .NCPU(NCPU), .CPU_W(CPU_W), .ON_CMD(ON_CMD), .OFF_CMD(OFF_CMD)
  ) u_fan (
    .clk     (clk),
    .rst     (rst),
    .cmd_we  (reg_we && reg_addr == A_CMD),
    .cmd     (reg_wdata),
    .apm_en  (smi_en[APM_EN_BIT]),
    .bcast   (negotiated[BCAST_BIT]),
    .cpu_idx (cpu_idx),
    .smi_req (smi_req),
    .acpi_on (acpi_on),
    .acpi_off(acpi_off)
  );

  smi_pm_regs u_pm (
    .clk        (clk),
    .rst        (rst),
    .en_we      (reg_we && reg_addr == A_SMIEN),
    .cfg_we     (reg_we && reg_addr == A_PMCFG),
    .rctl_we    (reg_we && reg_addr == A_RSTCTL),
    .wdata      (reg_wdata),
    .smi_en     (smi_en),
    .pm_cfg     (pm_cfg),
    .rst_cnt    (rst_cnt),
    .sys_rst_req(sys_rst_req)
  );

  logic [7:0] rd_mux;
  localparam logic [FEAT_W-1:0] SUP = HOST_FEATURES;

  always_comb begin
    rd_mux = '0;
    unique case (bank)
      BANK_SUP: rd_mux = SUP[lane*8 +: 8];
      BANK_REQ: rd_mux = requested[lane*8 +: 8];
      BANK_NEG: rd_mux = negotiated[lane*8 +: 8];
      default: begin
        if      (reg_addr == A_COMMIT) rd_mux = {7'b0, ok};
        else if (reg_addr == A_SMIEN)  rd_mux = smi_en;
        else if (reg_addr == A_PMCFG)  rd_mux = pm_cfg;
        else if (reg_addr == A_RSTCTL) rd_mux = rst_cnt;
        else                           rd_mux = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R1
  pulses_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> (smi_req == '0 && !acpi_on && !acpi_off && !sys_rst_req));
endmodule

// File: tb/smi_hub_bench.sv
module smi_hub_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam int CPU_W = 2;
  localparam logic [63:0] HOST = 64'h1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reg_we = 1'b0;
  logic [4:0]       reg_addr = '0;
  logic [7:0]       reg_wdata = '0;
  logic [7:0]       reg_rdata;
  logic [CPU_W-1:0] cpu_idx = '0;
  logic [NCPU-1:0]  smi_req;
  logic             acpi_on, acpi_off, sys_rst_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_hub #(.NCPU(NCPU), .HOST_FEATURES(HOST)) u_smi_hub (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_idx(cpu_idx),
    .smi_req(smi_req), .acpi_on(acpi_on), .acpi_off(acpi_off),
    .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, write lands at next posedge, sample at following negedge
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, {56'b0, v}, {56'b0, exp});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state and full address sweep
    chk("R1 outputs", {60'b0, smi_req, acpi_on, acpi_off, sys_rst_req} != 0, 0);
    for (int a = 0; a < 32; a++) begin
      logic [7:0] e;
      e = (a < 8) ? HOST[a*8 +: 8] : 8'h00;
      rd_chk($sformatf("R1 addr %0h", a), 5'(a), e);
    end

    // R3 APM enable clear: no SMI
    wr(5'h11, 8'h55);
    chk("R3 disabled no smi", {60'b0, smi_req}, 0);

    // R2 R3 R4 R11 full command sweep, single-CPU mode
    wr(5'h12, 8'h20);
    for (int v = 0; v < 256; v++) begin
      logic [3:0] e;
      cpu_idx = CPU_W'(v % NCPU);
      wr(5'h11, 8'(v));
      e = (v == 8'hF1 || v == 8'hF0) ? 4'b0 : 4'(1 << (v % NCPU));
      chk($sformatf("R3 R4 smi cmd %0h", v), {60'b0, smi_req}, {60'b0, e});
      chk($sformatf("R2 on cmd %0h", v), {63'b0, acpi_on}, {63'b0, v == 8'hF1});
      chk($sformatf("R2 off cmd %0h", v), {63'b0, acpi_off}, {63'b0, v == 8'hF0});
      @(negedge clk);
      chk($sformatf("R11 pulse end %0h", v), {60'b0, smi_req, acpi_on, acpi_off, sys_rst_req}, 0);
    end

    // R5 illegal low-lane bit
    wr(5'h08, 8'h03);
    wr(5'h10, 8'h01);
    rd_chk("R5 ok low", 5'h10, 8'h00);
    rd_chk("R5 neg low", 5'h18, 8'h00);
    // R5 illegal high-lane bit
    wr(5'h08, 8'h01);
    wr(5'h0F, 8'h80);
    wr(5'h10, 8'h01);
    rd_chk("R5 ok high", 5'h10, 8'h00);
    rd_chk("R5 neg high", 5'h18, 8'h00);

    // R8 byte lanes
    for (int b = 0; b < 8; b++) wr(5'(8 + b), 8'(8'h11 * (b + 1)));
    for (int b = 0; b < 8; b++)
      rd_chk($sformatf("R8 lane %0d", b), 5'(8 + b), 8'(8'h11 * (b + 1)));

    // R6 valid commit
    for (int b = 0; b < 8; b++) wr(5'(8 + b), (b == 0) ? 8'h01 : 8'h00);
    wr(5'h10, 8'h00);
    rd_chk("R6 ok", 5'h10, 8'h01);
    rd_chk("R6 R8 neg lane0", 5'h18, 8'h01);
    rd_chk("R6 R8 neg lane7", 5'h1F, 8'h00);

    // R4 broadcast
    cpu_idx = 2;
    wr(5'h11, 8'h42);
    chk("R4 broadcast", {60'b0, smi_req}, 64'hF);
    wr(5'h11, 8'hF1);
    chk("R2 after negotiation", {60'b0, smi_req, acpi_on}, 64'h1);

    // R7 commit after success ignored
    wr(5'h08, 8'h00);
    wr(5'h10, 8'h01);
    rd_chk("R7 neg kept", 5'h18, 8'h01);
    rd_chk("R7 ok kept", 5'h10, 8'h01);
    cpu_idx = 1;
    wr(5'h11, 8'h07);
    chk("R7 R4 still broadcast", {60'b0, smi_req}, 64'hF);

    // R9 lock
    wr(5'h12, 8'h21);
    wr(5'h13, 8'h10);
    rd_chk("R9 lock set", 5'h13, 8'h10);
    wr(5'h13, 8'h0F);
    rd_chk("R9 lock sticky", 5'h13, 8'h1F);
    wr(5'h12, 8'h00);
    rd_chk("R9 gbl frozen 1", 5'h12, 8'h01);
    wr(5'h12, 8'hFE);
    rd_chk("R9 others live", 5'h12, 8'hFF);

    // R10 reset control
    wr(5'h14, 8'hFF);
    chk("R10 pulse", {63'b0, sys_rst_req}, 64'h1);
    rd_chk("R10 nothing stored", 5'h14, 8'h00);
    wr(5'h14, 8'h0B);
    chk("R10 no pulse", {63'b0, sys_rst_req}, 64'h0);
    rd_chk("R10 keep bits", 5'h14, 8'h0A);
    wr(5'h14, 8'h06);
    rd_chk("R10 kept after request", 5'h14, 8'h0A);

    // R1 R9 reset clears everything but supported mask
    do_reset();
    rd_chk("R1 ok cleared", 5'h10, 8'h00);
    rd_chk("R1 neg cleared", 5'h18, 8'h00);
    rd_chk("R1 req cleared", 5'h08, 8'h00);
    rd_chk("R1 R9 lock cleared", 5'h13, 8'h00);
    rd_chk("R1 smien cleared", 5'h12, 8'h00);
    rd_chk("R1 rstctl cleared", 5'h14, 8'h00);
    rd_chk("R1 sup kept", 5'h00, HOST[7:0]);
    wr(5'h12, 8'h00);
    rd_chk("R9 unlocked after reset", 5'h12, 8'h00);
    wr(5'h12, 8'h20);
    cpu_idx = 3;
    wr(5'h11, 8'h10);
    chk("R4 single after reset", {60'b0, smi_req}, 64'h8);

    finish_run();
  end
endmodule